// File: doc/BRIEF.md
# EPP Parallel Cycle Controller

This block sits between a host register interface and an enhanced parallel port bus. It turns host accesses to the EPP address port (offset 3) and the four EPP data ports (offsets 4 to 7) into strobed handshake cycles with a peripheral. While a cycle runs, the host is stalled through a ready output. A watchdog limits how long a cycle may wait for the peripheral. If the limit passes, the cycle is aborted and a sticky timeout flag is raised in bit 0 of the status register.

Outside an EPP cycle the data bus acts as a plain or bidirectional port. It carries the byte last written to offset 0, and its direction comes from the control-register direction input. Two control inputs change a cycle. A reversed direction turns a requested write into a read on the bus, silently. A forced strobe input makes the bus drive and holds the write line low.

Host requests are single-cycle pulses on `host_wr` or `host_rd`, with the offset on `host_addr`. They are accepted only while `host_ready` is high, and a write wins when both pulse together.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset `host_ready` is 1, both strobes and `per_write_n` are 1, `epp_timeout` is 0, and `host_rdata` is 0.
- R2: An accepted EPP access (`epp_mode`=1, offset 3 to 7) drives `host_ready` low from the next cycle until the cycle after termination. A request made while `host_ready` is low is ignored.
- R3: If `per_wait_n` is 1 when a write starts, the bus is released (`pbus_oe`=0), no strobe is asserted and `per_write_n` stays 1 until `per_wait_n` is sampled 0. From the next cycle the block drives the byte with `pbus_oe`=1 and `per_write_n`=0. It asserts `per_dstb_n`=0 for offsets 4 to 7, or `per_astb_n`=0 for offset 3.
- R4: Once the peripheral drives `per_wait_n` high during a strobe, the strobe goes inactive in the next cycle. `host_ready` returns high one cycle after that.
- R5: If `per_wait_n` is 0 when a write is accepted, the strobe, `per_write_n`=0 and the driven byte appear in the very next cycle.
- R6: A read asserts the strobe with `per_write_n`=1 and `pbus_oe`=0. When `per_wait_n` is sampled high, it captures `pbus_in` into `host_rdata`.
- R7: If a cycle has not completed after `CLK_MHZ*TIMEOUT_US` busy cycles, it is aborted. The strobes go inactive, `host_ready` goes high and `epp_timeout` is set, all in the same cycle.
- R8: If `per_wait_n` high is sampled in the last allowed busy cycle, the cycle completes normally and `epp_timeout` is not set.
- R9: The timeout flag stays set until a host write to offset 1 with data bit 0 equal to 1. A read of offset 1 returns the flag in `host_rdata` bit 0, with the other bits 0.
- R10: An EPP write issued while `ctl_rev_dir`=1 runs as a read. `per_write_n` stays 1, `pbus_oe` stays 0, `pbus_in` is captured into `host_rdata`, and no error is flagged.
- R11: During any cycle, `ctl_stb_force`=1 forces `pbus_oe`=1 and `per_write_n`=0.
- R12: Outside a cycle, `pbus_oe` equals the inverse of `ctl_rev_dir` and `per_write_n` is 1. `pbus_out` holds the byte last written to offset 0, and a read of offset 0 returns `pbus_in`.
- R13: With `epp_mode`=0, accesses to offsets 3 to 7 start no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epp_mode | input | 1 | Enables EPP cycles on offsets 3 to 7 |
| ctl_rev_dir | input | 1 | Control-register direction bit (1 = bus input) |
| ctl_stb_force | input | 1 | Control-register strobe bit, forces write mode during a cycle |
| host_rd | input | 1 | Host read request pulse |
| host_wr | input | 1 | Host write request pulse |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Last captured read byte |
| host_ready | output | 1 | Low while the host is stalled by a cycle |
| pbus_in | input | 8 | Parallel data bus, input side |
| pbus_out | output | 8 | Parallel data bus, output side |
| pbus_oe | output | 1 | Parallel bus output enable |
| per_write_n | output | 1 | Active-low write indication to the peripheral |
| per_dstb_n | output | 1 | Active-low data strobe |
| per_astb_n | output | 1 | Active-low address strobe |
| per_wait_n | input | 1 | Peripheral wait handshake (high = may terminate) |
| epp_timeout | output | 1 | Sticky watchdog timeout flag (status bit 0) |

## Verification
The peripheral's release of the wait line and watchdog expiry can fall in the same clock edge. The bench provokes this by raising `per_wait_n` so that it is first sampled in exactly the last allowed busy cycle. A second run raises it one cycle later. The reference model settles each case independently: completion wins in the first run, and the abort with the timeout flag wins in the second. Every output is compared against the model on every clock.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WLOW = 2'd1,
    ST_STB  = 2'd2,
    ST_TERM = 2'd3
  } epp_state_e;

  localparam logic [2:0] OFF_SPP_DATA = 3'd0;
  localparam logic [2:0] OFF_STATUS   = 3'd1;
  localparam logic [2:0] OFF_EPP_ADDR = 3'd3;

  function automatic int unsigned wd_limit(input int unsigned clk_mhz, input int unsigned lim_us);
    return clk_mhz * lim_us;
  endfunction

  function automatic logic is_epp_port(input logic [2:0] off);
    return off >= OFF_EPP_ADDR;
  endfunction

  function automatic logic is_addr_port(input logic [2:0] off);
    return off == OFF_EPP_ADDR;
  endfunction

  function automatic logic [7:0] status_byte(input logic tmo);
    return {7'd0, tmo};
  endfunction

endpackage

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int unsigned LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic done,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = run && !done && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  a_r7_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(LIMIT)));

endmodule

// File: rtl/epp_handshake_fsm.sv
module epp_handshake_fsm
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_write,
  input  logic       go_read,
  input  logic       go_addr,
  input  logic       wait_n,
  input  logic       expire,
  output epp_state_e state,
  output logic       cyc_write,
  output logic       cyc_addr,
  output logic       run,
  output logic       ev_done
);

  assign run     = (state == ST_WLOW) || (state == ST_STB);
  assign ev_done = (state == ST_STB) && wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cyc_write <= 1'b0;
      cyc_addr  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go_write) begin
            cyc_write <= 1'b1;
            cyc_addr  <= go_addr;
            state     <= wait_n ? ST_WLOW : ST_STB;
          end else if (go_read) begin
            cyc_write <= 1'b0;
            cyc_addr  <= go_addr;
            state     <= ST_STB;
          end
        end
        ST_WLOW: begin
          if (expire)       state <= ST_IDLE;
          else if (!wait_n) state <= ST_STB;
        end
        ST_STB: begin
          if (ev_done)     state <= ST_TERM;
          else if (expire) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_term_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (state == ST_TERM));

  a_r3_wait_low_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WLOW) && wait_n && !expire) |=> (state == ST_WLOW));

endmodule

// File: rtl/epp_bus_drive.sv
module epp_bus_drive #(
  parameter int unsigned DW = 8
) (
  input  logic          busy,
  input  logic          drive_phase,
  input  logic          rev_dir,
  input  logic          stb_force,
  input  logic [DW-1:0] cyc_byte,
  input  logic [DW-1:0] spp_byte,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          write_n
);
  always_comb begin
    if (busy) begin
      bus_out = cyc_byte;
      bus_oe  = stb_force || drive_phase;
      write_n = !(stb_force || drive_phase);
    end else begin
      bus_out = spp_byte;
      bus_oe  = !rev_dir;
      write_n = 1'b1;
    end
  end
endmodule

// File: rtl/epp_host_regs.sv
module epp_host_regs
  import epp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          epp_go,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  input  logic          capture,
  input  logic          set_tmo,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] spp_byte,
  output logic [DW-1:0] cyc_byte,
  output logic          tmo
);
  logic clr_tmo;
  assign clr_tmo = wr_acc && (addr == OFF_STATUS) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      spp_byte <= '0;
      cyc_byte <= '0;
      tmo      <= 1'b0;
    end else begin
      if (set_tmo)      tmo <= 1'b1;
      else if (clr_tmo) tmo <= 1'b0;
      if (epp_go) cyc_byte <= wdata;
      if (wr_acc && !epp_go && (addr == OFF_SPP_DATA)) spp_byte <= wdata;
      if (capture)
        rdata <= bus_in;
      else if (rd_acc && !epp_go && (addr == OFF_SPP_DATA))
        rdata <= bus_in;
      else if (rd_acc && !epp_go && (addr == OFF_STATUS))
        rdata <= DW'(status_byte(tmo));
    end
  end

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !clr_tmo) |=> tmo);

endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned TIMEOUT_US = 10,
  parameter int unsigned DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epp_mode,
  input  logic          ctl_rev_dir,
  input  logic          ctl_stb_force,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [2:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  input  logic [DW-1:0] pbus_in,
  output logic [DW-1:0] pbus_out,
  output logic          pbus_oe,
  output logic          per_write_n,
  output logic          per_dstb_n,
  output logic          per_astb_n,
  input  logic          per_wait_n,
  output logic          epp_timeout
);
  localparam int unsigned WD_LIMIT = wd_limit(CLK_MHZ, TIMEOUT_US);

  epp_state_e state;
  logic cyc_write, cyc_addr, run, ev_done, ev_expire;
  logic idle, wr_acc, rd_acc, epp_go, go_write, go_read, busy, drive_phase, capture;
  logic [DW-1:0] spp_byte, cyc_byte;

  assign idle     = (state == ST_IDLE);
  assign wr_acc   = idle && host_wr;
  assign rd_acc   = idle && host_rd && !host_wr;
  assign epp_go   = (wr_acc || rd_acc) && epp_mode && is_epp_port(host_addr);
  assign go_write = epp_go && wr_acc && !ctl_rev_dir;
  assign go_read  = epp_go && !go_write;
  assign busy     = !idle;
  assign drive_phase = cyc_write && ((state == ST_STB) || (state == ST_TERM));
  assign capture  = ev_done && !cyc_write;

  assign host_ready = idle;
  assign per_dstb_n = !((state == ST_STB) && !cyc_addr);
  assign per_astb_n = !((state == ST_STB) && cyc_addr);

  epp_handshake_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go_write(go_write), .go_read(go_read), .go_addr(is_addr_port(host_addr)),
    .wait_n(per_wait_n), .expire(ev_expire),
    .state(state), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .run(run), .ev_done(ev_done)
  );

  epp_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .run(run), .done(ev_done), .expire(ev_expire)
  );

  epp_host_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc), .epp_go(epp_go),
    .addr(host_addr), .wdata(host_wdata), .bus_in(pbus_in),
    .capture(capture), .set_tmo(ev_expire),
    .rdata(host_rdata), .spp_byte(spp_byte), .cyc_byte(cyc_byte), .tmo(epp_timeout)
  );

  epp_bus_drive #(.DW(DW)) u_bus (
    .busy(busy), .drive_phase(drive_phase), .rev_dir(ctl_rev_dir), .stb_force(ctl_stb_force),
    .cyc_byte(cyc_byte), .spp_byte(spp_byte),
    .bus_out(pbus_out), .bus_oe(pbus_oe), .write_n(per_write_n)
  );

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!per_dstb_n && !per_astb_n));

  a_r2_strobe_stalls_host: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_dstb_n || !per_astb_n) |-> !host_ready);

  a_r7_abort_frees: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(epp_timeout) |-> (host_ready && per_dstb_n && per_astb_n));

  a_r8_done_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> $stable(epp_timeout));

  a_r11_force_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && ctl_stb_force) |-> (pbus_oe && !per_write_n));

  a_r6_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ((!per_dstb_n || !per_astb_n) && per_write_n) |-> !pbus_oe);

endmodule

// File: tb/epp_cycle_ctrl_bench.sv
`timescale 1ns/100ps
module epp_cycle_ctrl_bench;
  localparam int LIM = 2000; // 10 us at 5 ns per clock

  logic clk = 0, rst_n = 0;
  logic epp_mode = 1, ctl_rev_dir = 0, ctl_stb_force = 0;
  logic host_rd = 0, host_wr = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, pbus_in = 0;
  logic per_wait_n = 1;
  logic [7:0] host_rdata, pbus_out;
  logic host_ready, pbus_oe, per_write_n, per_dstb_n, per_astb_n, epp_timeout;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  epp_cycle_ctrl u_epp_cycle_ctrl (.*);

  always #2.5 clk = ~clk;

  // reference model
  int ph; bit mw, ma, mtmo; int el;
  logic [7:0] mbyte, mspp, mrd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mw = 0; ma = 0; mtmo = 0; el = 0; mbyte = 0; mspp = 0; mrd = 0;
    end else begin
      case (ph)
        0: if (host_wr || host_rd) begin
             if (epp_mode && host_addr >= 3) begin
               mbyte = host_wdata; ma = (host_addr == 3); el = 0;
               if (host_wr && !ctl_rev_dir) begin mw = 1; ph = per_wait_n ? 1 : 2; end
               else begin mw = 0; ph = 2; end
             end else if (host_wr) begin
               if (host_addr == 0) mspp = host_wdata;
               if (host_addr == 1 && host_wdata[0]) mtmo = 0;
             end else begin
               if (host_addr == 0) mrd = pbus_in;
               if (host_addr == 1) mrd = {7'd0, mtmo};
             end
           end
        1: begin el++; if (el == LIM) begin ph = 0; mtmo = 1; end else if (!per_wait_n) ph = 2; end
        2: begin
             el++;
             if (per_wait_n) begin ph = 3; if (!mw) mrd = pbus_in; end
             else if (el == LIM) begin ph = 0; mtmo = 1; end
           end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit act, drv;
      act = (ph != 0); drv = mw && ph >= 2;
      chk("R2 ready", host_ready, !act);
      chk("R3 dstb", per_dstb_n, !(ph == 2 && !ma));
      chk("R3 astb", per_astb_n, !(ph == 2 && ma));
      chk("R11 write_n", per_write_n, !((act && ctl_stb_force) || drv));
      chk("R12 oe", pbus_oe, act ? (ctl_stb_force || drv) : !ctl_rev_dir);
      chk("R12 bus", pbus_out, act ? mbyte : mspp);
      chk("R6 rdata", host_rdata, mrd);
      chk("R7 timeout", epp_timeout, mtmo);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic req(input bit wr, input logic [2:0] a, input logic [7:0] d);
    host_wr = wr; host_rd = !wr; host_addr = a; host_wdata = d;
    tick(1);
    host_wr = 0; host_rd = 0;
  endtask

  initial begin
    while (!done_flag && cyc < 200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R1
    chk("R1 ready", host_ready, 1); chk("R1 dstb", per_dstb_n, 1); chk("R1 astb", per_astb_n, 1);
    chk("R1 write_n", per_write_n, 1); chk("R1 timeout", epp_timeout, 0); chk("R1 rdata", host_rdata, 0);
    // R12
    req(1, 0, 8'hA5); chk("R12 spp byte", pbus_out, 8'hA5); chk("R12 oe", pbus_oe, 1);
    ctl_rev_dir = 1; tick(1); chk("R12 reversed", pbus_oe, 0);
    pbus_in = 8'h6E; req(0, 0, 0); chk("R12 read offset0", host_rdata, 8'h6E);
    ctl_rev_dir = 0; tick(1);
    // R3 / R2 / R4
    per_wait_n = 1; req(1, 4, 8'h5A); tick(3);
    chk("R3 no strobe yet", per_dstb_n, 1); chk("R3 bus released", pbus_oe, 0); chk("R2 stalled", host_ready, 0);
    per_wait_n = 0; tick(1);
    chk("R3 dstb", per_dstb_n, 0); chk("R3 write_n", per_write_n, 0); chk("R3 byte", pbus_out, 8'h5A);
    req(1, 0, 8'hFF); // ignored while busy
    per_wait_n = 1; tick(1);
    chk("R4 strobe off", per_dstb_n, 1); chk("R4 still stalled", host_ready, 0);
    tick(1); chk("R4 ready", host_ready, 1); chk("R2 ignored write", pbus_out, 8'hA5);
    // R5
    per_wait_n = 0; req(1, 3, 8'h77);
    chk("R5 astb", per_astb_n, 0); chk("R5 write_n", per_write_n, 0); chk("R5 byte", pbus_out, 8'h77);
    per_wait_n = 1; tick(2);
    // R6
    per_wait_n = 0; req(0, 4, 0);
    chk("R6 dstb", per_dstb_n, 0); chk("R6 write_n", per_write_n, 1); chk("R6 oe", pbus_oe, 0);
    pbus_in = 8'h3C; per_wait_n = 1; tick(2); chk("R6 captured", host_rdata, 8'h3C);
    // R11
    per_wait_n = 0; req(0, 5, 0); ctl_stb_force = 1; tick(1);
    chk("R11 oe", pbus_oe, 1); chk("R11 write_n", per_write_n, 0);
    ctl_stb_force = 0; per_wait_n = 1; tick(2);
    // R10
    ctl_rev_dir = 1; per_wait_n = 0; pbus_in = 8'h81; req(1, 4, 8'h11);
    chk("R10 write_n", per_write_n, 1); chk("R10 oe", pbus_oe, 0); chk("R10 dstb", per_dstb_n, 0);
    per_wait_n = 1; tick(2);
    chk("R10 captured", host_rdata, 8'h81); chk("R10 no error", epp_timeout, 0);
    ctl_rev_dir = 0; tick(1);
    // R7
    per_wait_n = 0; req(0, 4, 0); tick(LIM - 1);
    chk("R7 not yet", epp_timeout, 0); tick(1);
    chk("R7 timeout", epp_timeout, 1); chk("R7 ready", host_ready, 1); chk("R7 dstb", per_dstb_n, 1);
    // R9
    req(0, 1, 0); chk("R9 status read", host_rdata, 8'h01);
    req(1, 1, 8'h00); chk("R9 sticky", epp_timeout, 1);
    req(1, 1, 8'h01); chk("R9 cleared", epp_timeout, 0);
    req(0, 1, 0); chk("R9 status zero", host_rdata, 8'h00);
    // R8 collision: completion in the last allowed cycle
    per_wait_n = 0; req(1, 6, 8'h42); tick(LIM - 1); per_wait_n = 1; tick(2);
    chk("R8 no timeout", epp_timeout, 0); chk("R8 ready", host_ready, 1);
    // one cycle late: abort wins
    per_wait_n = 0; req(1, 6, 8'h43); tick(LIM); per_wait_n = 1; tick(1);
    chk("R7 late release", epp_timeout, 1);
    req(1, 1, 8'h01);
    // R13
    epp_mode = 0; req(1, 4, 8'h99);
    chk("R13 ready", host_ready, 1); chk("R13 dstb", per_dstb_n, 1); chk("R13 bus", pbus_out, 8'hA5);
    epp_mode = 1; tick(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done_flag = 1;
    $finish;
  end
endmodule